// File: doc/BRIEF.md
# Low-Transition Multi-Chain Scan Pattern Generator

This block is a built-in self-test stimulus source that drives several scan chains at once. A twisted-ring (Johnson) counter, whose width equals the scan length, provides the bits along the scan axis. A maximal-length LFSR provides one bit per chain. A row of XOR gates combines the two. Chain 0 receives the Johnson state unchanged. Every other chain j receives the Johnson state XORed with seed bit j-1. Between two patterns only one Johnson bit changes, so each chain's vector moves by a single bit.

The block has two operating modes. In scan mode each pattern is shifted out serially on one output per chain for a fixed number of cycles, and a one-cycle capture strobe follows. In parallel mode a whole pattern is presented on a wide bus each clock, with capture held high. A start strobe loads the programmed pattern count, resets the Johnson counter and the seed, and runs the sequence. A done pulse marks the end of the run.

Top module: `msic_tpg`

## Requirements
- R1: While reset is held and after it is released, `scan_out`, `par_out`, `capture` and `done` are all zero until a run starts.
- R2: In scan mode (`mode_scan`=1) each pattern takes LEN+1 cycles. There are LEN shift cycles carrying bit 0 first up to bit LEN-1, with `capture` low. One cycle follows with `capture` high and `scan_out` zero. Shift bit 0 of pattern 0 appears one cycle after the clock edge that samples `start`.
- R3: Bit k of chain j in pattern p equals J[k] XOR s_j. J is the Johnson state after p mod 2·LEN steps from all-zero, where each step shifts left and inserts the inverted MSB at bit 0. s_0 is 0 and s_j is bit j-1 of the seed.
- R4: Two consecutive vectors on chain 0 always differ in exactly one bit. Two consecutive vectors on any other chain differ in exactly one bit whenever both belong to the same block of 2·LEN patterns.
- R5: The seed starts at value 1. It advances once every 2·LEN patterns, together with the Johnson step that returns the counter to all-zero. For three seed bits the update is new = {s[1:0], s[2]^s[1]}. The seed is never zero.
- R6: Within the first 2·LEN·(2^(NCH-1)-1) patterns of a run, no full multi-chain pattern repeats.
- R7: In parallel mode (`mode_scan`=0), pattern p appears on `par_out` one cycle after p+1 edges have followed the start edge, with `capture` high. Chain j occupies bits [j·LEN +: LEN].
- R8: `done` is a one-cycle pulse in the cycle after the last capture. With a count of zero it comes one cycle after the start edge, and no capture is issued.
- R9: A `start` pulse that arrives while a run is in progress has no effect on the sequence, the count or the timing.
- R10: Every accepted `start` restarts the sequence from pattern 0, whatever state earlier runs left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_scan | input | 1 | 1 = serial scan mode, 0 = parallel per-clock mode; sampled with start |
| start | input | 1 | Begins a run when the block is idle |
| pat_count | input | CNTW | Number of patterns in the run; sampled with start |
| scan_out | output | NCH | One serial bit per chain during shift cycles |
| par_out | output | NCH*LEN | Full pattern in parallel mode, chain j at [j*LEN +: LEN] |
| capture | output | 1 | Capture strobe for the circuit under test |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Call the edge that samples `start` edge 0. In scan mode, shift bit k of pattern p is due after edge p·(LEN+1)+k+1. The capture for pattern p is due after edge (p+1)·(LEN+1). In parallel mode, pattern p is due after edge p+1. `done` is due one edge after the last capture. The bench counts edges from edge 0 and compares every output on the falling edge of each cycle against a behavioural model that computes each pattern directly from its index. It also rebuilds each chain's vector from the observed serial bits, to check the one-bit-change and no-repeat properties on the outputs themselves.

// File: rtl/msic_pkg.sv
package msic_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} msic_st_e;

  // feedback masks for maximal-length Fibonacci LFSRs, shift-left form
  function automatic logic [15:0] lfsr_taps(input int w);
    case (w)
      2:       return 16'h0003;
      3:       return 16'h0006;
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      8:       return 16'h00B8;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/msic_johnson.sv
module msic_johnson #(
  parameter int LEN = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  output logic [LEN-1:0] jq,
  output logic           at_last
);
  localparam logic [LEN-1:0] LAST_ST = {1'b1, {(LEN-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || load) jq <= '0;
    else if (step)   jq <= {jq[LEN-2:0], ~jq[LEN-1]};
  end

  assign at_last = (jq == LAST_ST);

  // R4
  sic_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> ($countones(jq ^ $past(jq)) == 1));

endmodule

// File: rtl/msic_seed_lfsr.sv
module msic_seed_lfsr #(
  parameter int             W    = 3,
  parameter logic [W-1:0]   INIT = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] seed
);
  import msic_pkg::*;
  localparam logic [15:0] TAPS_F = lfsr_taps(W);
  localparam logic [W-1:0] TAPS  = TAPS_F[W-1:0];

  always_ff @(posedge clk) begin
    if (rst || load) seed <= INIT;
    else if (step)   seed <= {seed[W-2:0], ^(seed & TAPS)};
  end

  // R5
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    seed != '0);

  // R5
  seed_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> seed != $past(seed));

endmodule

// File: rtl/msic_xor_net.sv
module msic_xor_net #(
  parameter int NCH = 4,
  parameter int LEN = 6
) (
  input  logic [LEN-1:0]     jv,
  input  logic [NCH-2:0]     seed,
  output logic [NCH*LEN-1:0] vecs
);
  for (genvar j = 0; j < NCH; j++) begin : g_chain
    if (j == 0) begin : g_base
      assign vecs[0 +: LEN] = jv;
    end else begin : g_mix
      assign vecs[j*LEN +: LEN] = jv ^ {LEN{seed[j-1]}};
    end
  end
endmodule

// File: rtl/msic_ctrl.sv
module msic_ctrl #(
  parameter int LEN  = 6,
  parameter int CNTW = 16,
  localparam int PHW = $clog2(LEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            mode_scan,
  input  logic [CNTW-1:0] pat_count,
  output logic            rld,
  output logic            adv,
  output logic            emit_scan,
  output logic            emit_par,
  output logic [PHW-1:0]  ph,
  output logic            cap_nxt,
  output logic            done_nxt
);
  import msic_pkg::*;
  localparam logic [PHW-1:0] PH_CAP = PHW'(LEN);

  msic_st_e        st_q;
  logic [CNTW-1:0] cnt_q, pcnt_q;
  logic            scan_q, last_pat;

  assign ph       = (st_q == ST_RUN) ? ph_q : '0;
  assign last_pat = (pcnt_q == cnt_q - CNTW'(1));

  logic [PHW-1:0] ph_q;

  always_comb begin
    rld = 1'b0; adv = 1'b0; emit_scan = 1'b0; emit_par = 1'b0;
    cap_nxt = 1'b0; done_nxt = 1'b0;
    case (st_q)
      ST_IDLE: rld = start;
      ST_RUN: begin
        if (scan_q) begin
          if (ph_q != PH_CAP) emit_scan = 1'b1;
          else begin cap_nxt = 1'b1; adv = 1'b1; end
        end else begin
          emit_par = 1'b1; cap_nxt = 1'b1; adv = 1'b1;
        end
      end
      ST_FIN:  done_nxt = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; ph_q <= '0; pcnt_q <= '0; cnt_q <= '0; scan_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          scan_q <= mode_scan;
          cnt_q  <= pat_count;
          pcnt_q <= '0;
          ph_q   <= '0;
          st_q   <= (pat_count == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (adv) begin
            ph_q   <= '0;
            pcnt_q <= pcnt_q + CNTW'(1);
            if (last_pat) st_q <= ST_FIN;
          end else begin
            ph_q <= ph_q + PHW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && start) |=> (cnt_q == $past(cnt_q) && scan_q == $past(scan_q)));

endmodule

// File: rtl/msic_tpg.sv
module msic_tpg #(
  parameter int               NCH       = 4,
  parameter int               LEN       = 6,
  parameter int               CNTW      = 16,
  parameter logic [NCH-2:0]   SEED_INIT = {{(NCH-2){1'b0}}, 1'b1}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_scan,
  input  logic                start,
  input  logic [CNTW-1:0]     pat_count,
  output logic [NCH-1:0]      scan_out,
  output logic [NCH*LEN-1:0]  par_out,
  output logic                capture,
  output logic                done
);
  localparam int SW  = NCH - 1;
  localparam int PHW = $clog2(LEN + 1);

  logic               rld, adv, emit_scan, emit_par, cap_nxt, done_nxt, j_last;
  logic [PHW-1:0]     ph;
  logic [LEN-1:0]     jq;
  logic [SW-1:0]      seed;
  logic [NCH*LEN-1:0] vecs;
  logic [NCH-1:0]     scan_nxt;

  msic_ctrl #(.LEN(LEN), .CNTW(CNTW)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .mode_scan(mode_scan),
    .pat_count(pat_count), .rld(rld), .adv(adv), .emit_scan(emit_scan),
    .emit_par(emit_par), .ph(ph), .cap_nxt(cap_nxt), .done_nxt(done_nxt));

  msic_johnson #(.LEN(LEN)) john_i (
    .clk(clk), .rst(rst), .load(rld), .step(adv), .jq(jq), .at_last(j_last));

  msic_seed_lfsr #(.W(SW), .INIT(SEED_INIT)) seed_i (
    .clk(clk), .rst(rst), .load(rld), .step(adv && j_last), .seed(seed));

  msic_xor_net #(.NCH(NCH), .LEN(LEN)) xnet_i (
    .jv(jq), .seed(seed), .vecs(vecs));

  for (genvar j = 0; j < NCH; j++) begin : g_sel
    logic [LEN-1:0] cv;
    assign cv          = vecs[j*LEN +: LEN];
    assign scan_nxt[j] = cv[ph];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_out <= '0; par_out <= '0; capture <= 1'b0; done <= 1'b0;
    end else begin
      scan_out <= emit_scan ? scan_nxt : '0;
      if (emit_par) par_out <= vecs;
      capture  <= cap_nxt;
      done     <= done_nxt;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_no_cap_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !capture);

endmodule

// File: tb/msic_tpg_tb.sv
module msic_tpg_tb_top;
  localparam int NCH = 4;
  localparam int LEN = 6;
  localparam int CNTW = 16;
  localparam int PW = NCH * LEN;
  localparam int PERIOD = 2 * LEN * 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_scan = 1'b0;
  logic start = 1'b0;
  logic [CNTW-1:0] pat_count = '0;
  logic [NCH-1:0] scan_out;
  logic [PW-1:0] par_out;
  logic capture, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [PW-1:0] seen[$];
  logic [PW-1:0] prev_pat;

  always #2 clk = ~clk;

  msic_tpg #(.NCH(NCH), .LEN(LEN), .CNTW(CNTW)) dut_i (
    .clk(clk), .rst(rst), .mode_scan(mode_scan), .start(start),
    .pat_count(pat_count), .scan_out(scan_out), .par_out(par_out),
    .capture(capture), .done(done));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LEN-1:0] john_at(input int t);
    logic [LEN-1:0] b;
    for (int k = 0; k < LEN; k++) b[k] = (t <= LEN) ? (k < t) : (k >= t - LEN);
    return b;
  endfunction

  function automatic logic [NCH-2:0] seed_at(input int e);
    logic [2:0] s = 3'b001;
    for (int i = 0; i < e; i++) s = {s[1:0], s[2] ^ s[1]};
    return s;
  endfunction

  function automatic logic [PW-1:0] pat_at(input int p);
    logic [PW-1:0] r;
    logic [LEN-1:0] jv = john_at(p % (2 * LEN));
    logic [NCH-2:0] s = seed_at(p / (2 * LEN));
    for (int j = 0; j < NCH; j++)
      r[j*LEN +: LEN] = (j == 0) ? jv : (jv ^ {LEN{s[j-1]}});
    return r;
  endfunction

  // SIC and uniqueness on an observed pattern
  task automatic judge(input int p, input logic [PW-1:0] obs);
    bit dup = 0;
    if (p > 0) begin
      for (int j = 0; j < NCH; j++) begin
        if (j == 0 || (p % (2 * LEN)) != 0) begin
          logic [LEN-1:0] d = obs[j*LEN +: LEN] ^ prev_pat[j*LEN +: LEN];
          chk($countones(d) == 1, "R4 one-bit change per chain", 64'($countones(d)), 64'd1);
        end
      end
    end
    foreach (seen[i]) if (seen[i] == obs) dup = 1;
    if (p < PERIOD) chk(!dup, "R6 no repeated pattern", 64'(obs), 64'(0));
    seen.push_back(obs);
    prev_pat = obs;
  endtask

  task automatic run(input bit scan, input int count, input int pulse_at);
    logic [PW-1:0] got;
    int ncyc = scan ? count * (LEN + 1) : count;
    seen.delete();
    got = '0;
    @(negedge clk);
    mode_scan = scan; pat_count = CNTW'(count); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= ncyc; i++) begin
      @(negedge clk);
      if (start) start = 1'b0;
      if (scan) begin
        int p = (i - 1) / (LEN + 1);
        int r = (i - 1) % (LEN + 1);
        logic [PW-1:0] ep = pat_at(p);
        if (r < LEN) begin
          logic [NCH-1:0] es;
          for (int j = 0; j < NCH; j++) begin
            es[j] = ep[j*LEN + r];
            got[j*LEN + r] = scan_out[j];
          end
          chk(scan_out == es, "R2/R3 shift bit", 64'(scan_out), 64'(es));
          chk(capture == 1'b0, "R2 no capture while shifting", 64'(capture), 64'd0);
        end else begin
          chk(capture == 1'b1, "R2 capture after LEN shifts", 64'(capture), 64'd1);
          chk(scan_out == '0, "R2 quiet scan_out at capture", 64'(scan_out), 64'd0);
          chk(got == ep, "R3 R5 rebuilt vector", 64'(got), 64'(ep));
          judge(p, got);
        end
      end else begin
        logic [PW-1:0] ep = pat_at(i - 1);
        chk(capture == 1'b1, "R7 capture each cycle", 64'(capture), 64'd1);
        chk(par_out == ep, "R7 parallel pattern", 64'(par_out), 64'(ep));
        judge(i - 1, par_out);
      end
      chk(done == 1'b0, "R8 no early done", 64'(done), 64'd0);
      // R9: start pulse during the run, sampled at the next edge
      if (i == pulse_at) start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R8 done after last capture", 64'(done), 64'd1);
    chk(capture == 1'b0, "R8 no capture with done", 64'(capture), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done lasts one cycle", 64'(done), 64'd0);
    chk(capture == 1'b0, "R9 no extra pattern after run", 64'(capture), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(scan_out == '0 && par_out == '0, "R1 reset outputs", 64'(par_out), 64'd0);
    chk(!capture && !done, "R1 reset strobes", 64'({capture, done}), 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(scan_out == '0 && !capture && !done, "R1 idle after reset", 64'({scan_out, capture, done}), 64'd0);
    // full period in scan mode: R2 R3 R4 R5 R6 R8
    run(1'b1, PERIOD, 0);
    // parallel mode with a stray start mid-run: R7 R9
    run(1'b0, 30, 10);
    // restart from a non-initial state: R10
    run(1'b1, 3, 8);
    // zero count: R8
    run(1'b0, 0, 0);
    // parallel mode again from scratch: R10
    run(1'b0, 2 * LEN + 3, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule